// File: doc/BRIEF.md
# CAN Receive Acceptance Filter Matcher

This block chooses which receive message object, if any, takes an incoming CAN frame. When a frame header arrives, each of the 32 candidate objects is checked against the frame's identifier, its extended-format flag and its direction bit. An object can hold a per-bit identifier mask, so a single object can accept a range of identifiers. It can also skip the format and direction checks. Objects that are not marked valid never take part.

Each object's stored identifier is read as 11 or 29 bits, depending on the object's own extended flag. A standard identifier sits in the top 11 bits of the 29-bit identifier field. When more than one object accepts the frame, the object with the lowest number wins. The decision is registered, and it appears one cycle after the header strobe. It then holds until the next strobe.

Top module: `can_filt_match`

## Requirements
- R1: After reset, `res_valid`, `match_hit` and `match_idx` are all 0.
- R2: `res_valid` is 1 in exactly the cycle after each cycle in which `hdr_valid` is 1, and 0 otherwise. `match_hit` and `match_idx` change only in that cycle and hold their value at all other times.
- R3: An object whose `obj_valid` bit is 0 never matches, whatever its other fields hold.
- R4: When an object's `obj_use_mask` bit is 0, every identifier bit must be equal. The frame's extended flag must equal `obj_ext`, and the frame's direction must equal `obj_dir`.
- R5: When `obj_use_mask` is 1, an identifier bit whose `mask_id` bit is 1 must be equal, and an identifier bit whose `mask_id` bit is 0 is not compared.
- R6: For an object with `obj_ext`=0, frame identifier bits 10:0 are compared with stored identifier bits 28:18. Stored bits 17:0 and frame bits 28:11 play no part.
- R7: For an object with `obj_ext`=1, all 29 identifier bits (28:0) are compared.
- R8: When `obj_use_mask`=1 and `mask_ext_en`=0, the frame's extended flag is not compared. When `mask_ext_en`=1, it must equal `obj_ext`.
- R9: When `obj_use_mask`=1 and `mask_dir_en`=0, the frame's direction bit is not compared. When `mask_dir_en`=1, it must equal `obj_dir`.
- R10: If several objects match, `match_idx` is the lowest matching object number and `match_hit` is 1. If no object matches, `match_hit` is 0 and `match_idx` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| hdr_valid | input | 1 | Frame header strobe |
| hdr_id | input | 29 | Frame identifier. A standard frame uses bits 10:0 |
| hdr_ext | input | 1 | Frame uses the extended identifier format |
| hdr_dir | input | 1 | Frame direction bit |
| obj_valid | input | 32 | Per-object valid bit; bit i belongs to object i |
| obj_ext | input | 32 | Per-object extended-format flag |
| obj_dir | input | 32 | Per-object direction bit |
| obj_id | input | 928 | Stored identifiers; object i uses bits [i*29 +: 29] |
| obj_use_mask | input | 32 | Per-object mask enable |
| mask_id | input | 928 | Identifier masks, same layout as obj_id; 1 means the bit is compared |
| mask_ext_en | input | 32 | Per-object enable for the extended-flag compare when masking |
| mask_dir_en | input | 32 | Per-object enable for the direction compare when masking |
| res_valid | output | 1 | Decision valid, one cycle after the strobe |
| match_hit | output | 1 | At least one object accepted the frame |
| match_idx | output | 5 | Lowest accepting object number |

## Verification
The assertions check the result-timing contract on every cycle: the one-cycle pulse after each strobe and the holding of the outputs between strobes. They also check that a miss always reports object 0, and that a reported hit never names an object that was invalid at the strobe. Whether the right object is chosen depends on the identifier, format and direction rules, and only the bench's scenarios can show that. These scenarios are a fixed table of frames against a mixed object set, followed by priority tests at objects 0 and 31.

// File: rtl/can_filt_pkg.sv
package can_filt_pkg;
    localparam int unsigned CAN_EXT_ID_W = 29;
    localparam int unsigned CAN_STD_ID_W = 11;
    localparam int unsigned CAN_NUM_OBJ  = 32;

    typedef struct packed {
        logic       vld;
        logic       hit;
        logic [4:0] idx;
    } filt_res_t;
endpackage

// File: rtl/can_filt_cmp.sv
module can_filt_cmp #(
    parameter int unsigned ID_W  = 29,
    parameter int unsigned STD_W = 11
) (
    input  logic [ID_W-1:0] hdr_id,
    input  logic            hdr_ext,
    input  logic            hdr_dir,
    input  logic            o_valid,
    input  logic            o_ext,
    input  logic            o_dir,
    input  logic            o_use_mask,
    input  logic [ID_W-1:0] o_id,
    input  logic [ID_W-1:0] o_mask,
    input  logic            o_ext_en,
    input  logic            o_dir_en,
    output logic            hit
);
    logic [ID_W-1:0]  eff_mask;
    logic [ID_W-1:0]  diff_long;
    logic [STD_W-1:0] diff_short;
    logic             id_ok;
    logic             ext_ok;
    logic             dir_ok;

    always_comb begin
        eff_mask   = o_use_mask ? o_mask : '1;
        diff_long  = (hdr_id ^ o_id) & eff_mask;
        diff_short = (hdr_id[STD_W-1:0] ^ o_id[ID_W-1 -: STD_W]) & eff_mask[ID_W-1 -: STD_W];
        id_ok      = o_ext ? ~|diff_long : ~|diff_short;
        ext_ok     = (hdr_ext == o_ext) | (o_use_mask & ~o_ext_en);
        dir_ok     = (hdr_dir == o_dir) | (o_use_mask & ~o_dir_en);
        hit        = o_valid & id_ok & ext_ok & dir_ok;
    end
endmodule

// File: rtl/can_filt_prio.sv
module can_filt_prio #(
    parameter int unsigned N     = 32,
    parameter int unsigned IDX_W = 5
) (
    input  logic [N-1:0]     req,
    output logic             any,
    output logic [IDX_W-1:0] first
);
    always_comb begin
        any   = |req;
        first = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) first = IDX_W'(i);
        end
    end
endmodule

// File: rtl/can_filt_match.sv
module can_filt_match
    import can_filt_pkg::*;
#(
    parameter int unsigned NUM_OBJ = CAN_NUM_OBJ,
    parameter int unsigned ID_W    = CAN_EXT_ID_W,
    parameter int unsigned STD_W   = CAN_STD_ID_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    hdr_valid,
    input  logic [ID_W-1:0]         hdr_id,
    input  logic                    hdr_ext,
    input  logic                    hdr_dir,
    input  logic [NUM_OBJ-1:0]      obj_valid,
    input  logic [NUM_OBJ-1:0]      obj_ext,
    input  logic [NUM_OBJ-1:0]      obj_dir,
    input  logic [NUM_OBJ*ID_W-1:0] obj_id,
    input  logic [NUM_OBJ-1:0]      obj_use_mask,
    input  logic [NUM_OBJ*ID_W-1:0] mask_id,
    input  logic [NUM_OBJ-1:0]      mask_ext_en,
    input  logic [NUM_OBJ-1:0]      mask_dir_en,
    output logic                    res_valid,
    output logic                    match_hit,
    output logic [((NUM_OBJ > 1) ? $clog2(NUM_OBJ) : 1)-1:0] match_idx
);
    localparam int unsigned IDX_W = (NUM_OBJ > 1) ? $clog2(NUM_OBJ) : 1;

    typedef struct packed {
        logic             vld;
        logic             hit;
        logic [IDX_W-1:0] idx;
    } res_t;

    logic [NUM_OBJ-1:0] obj_hit;
    logic               any_hit;
    logic [IDX_W-1:0]   first_hit;
    res_t               res_d;
    res_t               res_q;

    for (genvar g = 0; g < NUM_OBJ; g++) begin : g_obj
        can_filt_cmp #(.ID_W(ID_W), .STD_W(STD_W)) u_cmp (
            .hdr_id     (hdr_id),
            .hdr_ext    (hdr_ext),
            .hdr_dir    (hdr_dir),
            .o_valid    (obj_valid[g]),
            .o_ext      (obj_ext[g]),
            .o_dir      (obj_dir[g]),
            .o_use_mask (obj_use_mask[g]),
            .o_id       (obj_id[g*ID_W +: ID_W]),
            .o_mask     (mask_id[g*ID_W +: ID_W]),
            .o_ext_en   (mask_ext_en[g]),
            .o_dir_en   (mask_dir_en[g]),
            .hit        (obj_hit[g])
        );
    end

    can_filt_prio #(.N(NUM_OBJ), .IDX_W(IDX_W)) u_prio (
        .req   (obj_hit),
        .any   (any_hit),
        .first (first_hit)
    );

    always_comb begin
        res_d     = res_q;
        res_d.vld = hdr_valid;
        if (hdr_valid) begin
            res_d.hit = any_hit;
            res_d.idx = any_hit ? first_hit : '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) res_q <= '0;
        else        res_q <= res_d;
    end

    assign res_valid = res_q.vld;
    assign match_hit = res_q.hit;
    assign match_idx = res_q.idx;
endmodule

// File: rtl/can_filt_match_chk.sv
module can_filt_match_chk #(
    parameter int unsigned NUM_OBJ = 32,
    parameter int unsigned IDX_W   = 5
) (
    input logic               clk,
    input logic               rst_n,
    input logic               hdr_valid,
    input logic [NUM_OBJ-1:0] obj_valid,
    input logic               res_valid,
    input logic               match_hit,
    input logic [IDX_W-1:0]   match_idx
);
    logic [NUM_OBJ-1:0] valid_snap;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         valid_snap <= '0;
        else if (hdr_valid) valid_snap <= obj_valid;
    end

    assert_vld_after_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
        hdr_valid |=> res_valid);
    assert_vld_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !hdr_valid |=> !res_valid);
    assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !hdr_valid |=> ($stable(match_hit) && $stable(match_idx)));
    assert_miss_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !match_hit |-> (match_idx == '0));
    assert_hit_valid_obj_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && match_hit) |-> valid_snap[match_idx]);
    assert_none_valid_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && (valid_snap == '0)) |-> !match_hit);
endmodule

bind can_filt_match can_filt_match_chk #(.NUM_OBJ(NUM_OBJ), .IDX_W(IDX_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .hdr_valid (hdr_valid),
    .obj_valid (obj_valid),
    .res_valid (res_valid),
    .match_hit (match_hit),
    .match_idx (match_idx)
);

// File: tb/can_filt_match_test.sv
module can_filt_match_test;
    localparam int N = 32;
    localparam int W = 29;

    logic            clk = 0;
    logic            rst_n = 0;
    logic            hdr_valid = 0;
    logic [W-1:0]    hdr_id = '0;
    logic            hdr_ext = 0;
    logic            hdr_dir = 0;
    logic [N-1:0]    obj_valid = '0, obj_ext = '0, obj_dir = '0, obj_use_mask = '0;
    logic [N-1:0]    mask_ext_en = '0, mask_dir_en = '0;
    logic [N*W-1:0]  obj_id = '0, mask_id = '0;
    logic            res_valid, match_hit;
    logic [4:0]      match_idx;
    int              checks = 0;
    int              errors = 0;

    always #5 clk = ~clk;

    can_filt_match uut (.*);

    // {id[28:0], ext, dir, exp_hit, exp_idx[4:0]}
    localparam logic [36:0] VEC [12] = '{
        {29'h0000123, 1'b0, 1'b0, 1'b1, 5'd3},   // R4 exact std, R10 3 beats 7
        {29'h000012F, 1'b0, 1'b0, 1'b1, 5'd7},   // R5 masked low bits
        {29'h000012F, 1'b1, 1'b1, 1'b1, 5'd7},   // R8 R9 flags ignored
        {29'h1ABCD55, 1'b1, 1'b0, 1'b1, 5'd5},   // R7 ext with mask
        {29'h1ABCD55, 1'b0, 1'b0, 1'b0, 5'd0},   // R8 ext compare enforced
        {29'h1ABCD55, 1'b1, 1'b1, 1'b0, 5'd0},   // R9 dir compare enforced
        {29'h0000300, 1'b0, 1'b0, 1'b0, 5'd0},   // R3 invalid object 9
        {29'h0000555, 1'b0, 1'b1, 1'b1, 5'd12},  // R4 dir exact
        {29'h0000555, 1'b0, 1'b0, 1'b0, 5'd0},   // R4 dir mismatch
        {29'h1ABCEE0, 1'b1, 1'b0, 1'b0, 5'd0},   // R5 cared bit differs
        {29'h1FFFF923, 1'b0, 1'b0, 1'b1, 5'd3},  // R6 upper frame bits ignored
        {29'h0ABCDE0, 1'b1, 1'b0, 1'b0, 5'd0}    // R7 bit 28 compared
    };

    function automatic string vec_tag(input int k);
        case (k)
            0, 7, 8: return "R4";
            1, 9:    return "R5";
            2:       return "R8";
            3, 11:   return "R7";
            4:       return "R8";
            5:       return "R9";
            6:       return "R3";
            default: return "R6";
        endcase
    endfunction

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %0h expected %0h", tag, got, exp);
        end
    endtask

    task automatic set_obj(input int i, input logic v, input logic e, input logic d,
                           input logic um, input logic [W-1:0] id, input logic [W-1:0] msk,
                           input logic me, input logic md);
        obj_valid[i] = v; obj_ext[i] = e; obj_dir[i] = d; obj_use_mask[i] = um;
        obj_id[i*W +: W] = id; mask_id[i*W +: W] = msk;
        mask_ext_en[i] = me; mask_dir_en[i] = md;
    endtask

    task automatic send(input logic [W-1:0] id, input logic e, input logic d);
        @(negedge clk);
        hdr_id = id; hdr_ext = e; hdr_dir = d; hdr_valid = 1;
        @(negedge clk);
        hdr_valid = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog got timeout expected completion");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        // object set for the table
        set_obj(3,  1, 0, 0, 0, 29'h48EA5A5, 29'h0,        0, 0);
        set_obj(5,  1, 1, 0, 1, 29'h1ABCDE0, 29'h1FFFFF00, 1, 1);
        set_obj(7,  1, 0, 0, 1, 29'h4800000, 29'h1FC00000, 0, 0);
        set_obj(9,  0, 0, 0, 0, 29'hC000000, 29'h0,        0, 0);
        set_obj(12, 1, 0, 1, 0, 29'h15540000, 29'h0,       0, 0);

        repeat (2) @(negedge clk);
        check("R1 res_valid", res_valid, 0);
        check("R1 match_hit", match_hit, 0);
        check("R1 match_idx", match_idx, 0);
        rst_n = 1;

        for (int k = 0; k < 12; k++) begin
            send(VEC[k][36:8], VEC[k][7], VEC[k][6]);
            check({vec_tag(k), " valid"}, res_valid, 1);
            check({vec_tag(k), " hit"}, match_hit, VEC[k][5]);
            check({vec_tag(k), " idx"}, match_idx, VEC[k][4:0]);
        end

        // R2: hold between strobes
        send(29'h0000555, 0, 1);
        hdr_id = 29'h0000123; hdr_dir = 0;
        @(negedge clk);
        check("R2 pulse ends", res_valid, 0);
        @(negedge clk);
        check("R2 hold hit", match_hit, 1);
        check("R2 hold idx", match_idx, 12);

        // R10: catch-all objects at both ends
        for (int i = 0; i < N; i++) set_obj(i, 0, 0, 0, 0, '0, '0, 0, 0);
        set_obj(0,  1, 1, 1, 1, 29'h0, 29'h0, 0, 0);
        set_obj(31, 1, 0, 0, 1, 29'h0, 29'h0, 0, 0);
        send(29'h1234567, 1, 0);
        check("R10 lowest idx", match_idx, 0);
        check("R10 lowest hit", match_hit, 1);
        obj_valid[0] = 0;
        send(29'h1234567, 1, 0);
        check("R3 skip invalid idx", match_idx, 31);
        obj_valid[31] = 0;
        send(29'h1234567, 1, 0);
        check("R3 none valid hit", match_hit, 0);
        check("R10 miss idx", match_idx, 0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule